// File: doc/BRIEF.md
# Configurable Input Glitch Filter

This block cleans up one asynchronous timer input before it reaches edge detection and capture logic. The raw pin first passes through a two-flop synchroniser clocked by the kernel clock. A sampling stage then looks at the synchronised level at a chosen rate. The output level moves to a new value only after a run of consecutive samples all show that value. A single 4-bit filter code sets both the sampling rate and the run length.

The sampling rate is either the kernel clock itself or a slower dead-time clock. The dead-time clock reaches the block as a one-cycle enable pulse, and a code can divide it further by 2, 4, 8, 16 or 32. The run length N comes from an irregular fixed table. When the code changes, the block restarts the sample divider and the run counter, and the output keeps its present level.

Top module: `tgf_top`

## Requirements
- R1: While reset is active, and on the first cycle after it, `filt_o` is 0 and the run counter is cleared.
- R2: A change on `raw_i` needs two synchroniser flops before it reaches the filter. With code 0, a level applied before clock edge k appears on `filt_o` right after edge k+2.
- R3: Code 0 takes a sample every kernel cycle with N=1, so `filt_o` follows the synchronised input with no filtering.
- R4: Codes 1, 2 and 3 take a sample every kernel cycle, with N of 2, 4 and 8.
- R5: Codes 4 and up take a sample on every D-th `dt_en_i` pulse. D is 2 for codes 4-5, 4 for codes 6-7, 8 for codes 8-9, 16 for codes 10-12 and 32 for codes 13-15.
- R6: For the codes of R5, N is 6 for code 4, 8 for code 5, 6 for 6, 8 for 7, 6 for 8, 8 for 9, 5/6/8 for codes 10/11/12 and 5/6/8 for codes 13/14/15.
- R7: A sample equal to the current output clears the run counter. A pulse lasting fewer than N samples therefore never reaches `filt_o`.
- R8: On any cycle where `fcode_i` differs from its value in the previous cycle, the divider and the run counter restart and `filt_o` holds.
- R9: `filt_o` changes only on a sample cycle. With a code of 4 or more and `dt_en_i` held low, the output never changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| raw_i | input | 1 | Raw asynchronous input level |
| fcode_i | input | 4 | Filter code selecting sample rate and N |
| dt_en_i | input | 1 | One-cycle pulse per dead-time clock period |
| filt_o | output | 1 | Filtered input level |

## Verification
A clean step under code 0 fixes the exact synchroniser latency. For codes 1 to 3, a glitch one sample short of N followed by a full-length pulse shows the threshold is exactly N and not N-1 or N+1. A sweep over all the dead-time codes with a steady enable cadence separates the divider ratio from the run length. Holding the enable low, and changing the code in the middle of a run, show that the output holds and that the counter truly restarts rather than carrying over.

// File: rtl/tgf_pkg.sv
package tgf_pkg;

  localparam int CODE_W = 4;

  typedef struct packed {
    logic       use_dt;    // sample on divided dead-time pulses
    logic [2:0] div_log2;  // divider = 2**div_log2
    logic [3:0] n_req;     // consecutive samples required
  } fcfg_t;

  // Decode of the filter code into sample source, divider and run length.
  function automatic fcfg_t decode_code(input logic [CODE_W-1:0] c);
    fcfg_t r;
    r.use_dt   = (c >= 4'd4);
    r.div_log2 = 3'd0;
    r.n_req    = 4'd1;
    case (c)
      4'd1:  r.n_req = 4'd2;
      4'd2:  r.n_req = 4'd4;
      4'd3:  r.n_req = 4'd8;
      4'd4:  begin r.div_log2 = 3'd1; r.n_req = 4'd6; end
      4'd5:  begin r.div_log2 = 3'd1; r.n_req = 4'd8; end
      4'd6:  begin r.div_log2 = 3'd2; r.n_req = 4'd6; end
      4'd7:  begin r.div_log2 = 3'd2; r.n_req = 4'd8; end
      4'd8:  begin r.div_log2 = 3'd3; r.n_req = 4'd6; end
      4'd9:  begin r.div_log2 = 3'd3; r.n_req = 4'd8; end
      4'd10: begin r.div_log2 = 3'd4; r.n_req = 4'd5; end
      4'd11: begin r.div_log2 = 3'd4; r.n_req = 4'd6; end
      4'd12: begin r.div_log2 = 3'd4; r.n_req = 4'd8; end
      4'd13: begin r.div_log2 = 3'd5; r.n_req = 4'd5; end
      4'd14: begin r.div_log2 = 3'd5; r.n_req = 4'd6; end
      4'd15: begin r.div_log2 = 3'd5; r.n_req = 4'd8; end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tgf_sync.sv
module tgf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tgf_tick.sv
module tgf_tick #(
  parameter int DIV_W = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       use_dt_i,
  input  logic [2:0] div_log2_i,
  input  logic       dt_en_i,
  output logic       tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   ratio;
  logic             last_slot;

  assign ratio     = (DIV_W+1)'(1) << div_log2_i;
  assign last_slot = ({1'b0, div_q} == ratio - (DIV_W+1)'(1));
  assign tick_o    = !restart_i && (!use_dt_i || (dt_en_i && last_slot));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 div_q <= '0;
    else if (restart_i)          div_q <= '0;
    else if (use_dt_i && dt_en_i) div_q <= last_slot ? '0 : div_q + 1'b1;
  end

  // R5: a dead-time pulse on the final slot wraps the divider
  p_div_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (use_dt_i && dt_en_i && tick_o) |=> (div_q == '0));

  // R5: a dead-time pulse before the final slot advances the divider by one
  p_div_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (use_dt_i && dt_en_i && !tick_o && !restart_i) |=> (div_q == $past(div_q) + 1'b1));
endmodule

// File: rtl/tgf_core.sv
module tgf_core #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic             smp_i,
  input  logic [CNT_W-1:0] n_req_i,
  output logic             filt_o
);
  logic [CNT_W-1:0] run_q;
  logic [CNT_W:0]   run_next;
  logic             differs;
  logic             reached;

  assign differs  = (smp_i != filt_o);
  assign run_next = {1'b0, run_q} + 1'b1;
  assign reached  = (run_next >= {1'b0, n_req_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_o <= 1'b0;
      run_q  <= '0;
    end else if (restart_i) begin
      run_q  <= '0;
    end else if (tick_i) begin
      if (!differs) begin
        run_q <= '0;
      end else if (reached) begin
        filt_o <= smp_i;
        run_q  <= '0;
      end else begin
        run_q <= run_next[CNT_W-1:0];
      end
    end
  end

  // R9: no sample, no output change
  p_hold_no_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(filt_o));

  // R7: an agreeing sample keeps the output and clears the run
  p_agree_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !differs) |=> ($stable(filt_o) && run_q == '0));

  // R8: a code change holds the output and restarts the run
  p_restart_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> ($stable(filt_o) && run_q == '0));

  // R6: the run counter never reaches the required length
  p_run_below_n_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |-> (run_q < n_req_i));
endmodule

// File: rtl/tgf_top.sv
module tgf_top
  import tgf_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 5,
  parameter int CNT_W       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              raw_i,
  input  logic [CODE_W-1:0] fcode_i,
  input  logic              dt_en_i,
  output logic              filt_o
);
  logic [CODE_W-1:0] code_q;
  logic              code_chg;
  fcfg_t             cfg;
  logic              smp;
  logic              tick;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) code_q <= '0;
    else         code_q <= fcode_i;

  assign code_chg = (fcode_i != code_q);
  assign cfg      = decode_code(fcode_i);

  tgf_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (raw_i), .q_o (smp)
  );

  tgf_tick #(.DIV_W(DIV_W)) i_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (code_chg),
    .use_dt_i   (cfg.use_dt),
    .div_log2_i (cfg.div_log2),
    .dt_en_i    (dt_en_i),
    .tick_o     (tick)
  );

  tgf_core #(.CNT_W(CNT_W)) i_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (code_chg),
    .tick_i    (tick),
    .smp_i     (smp),
    .n_req_i   (CNT_W'(cfg.n_req)),
    .filt_o    (filt_o)
  );

  // R8: no sample is taken on the cycle the code changes
  p_no_tick_on_change_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_chg |-> !tick);

  // R9: dead-time codes sample only on an enable pulse
  p_dt_needs_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcode_i >= 4'd4 && !dt_en_i) |=> $stable(filt_o));
endmodule

// File: tb/test_tgf_top.sv
module test_tgf_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raw = 1'b0;
  logic [3:0] code = 4'd0;
  logic       dt_en = 1'b0;
  logic       filt;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;
  bit  dt_run   = 1'b0;
  int  dt_phase = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;  // 50 MHz

  tgf_top i_tgf_top (
    .clk_i (clk), .rst_ni (rst_n), .raw_i (raw),
    .fcode_i (code), .dt_en_i (dt_en), .filt_o (filt)
  );

  // dead-time pulse: one cycle in three
  always @(negedge clk) begin
    dt_phase <= (dt_phase == 2) ? 0 : dt_phase + 1;
    dt_en    <= dt_run && (dt_phase == 2);
  end

  // expected-behaviour tables written from the requirements
  function automatic int ratio_of(input logic [3:0] c);
    if (c < 4)  return 1;
    if (c < 6)  return 2;
    if (c < 8)  return 4;
    if (c < 10) return 8;
    if (c < 13) return 16;
    return 32;
  endfunction

  function automatic int runlen_of(input logic [3:0] c);
    int t;
    if (c == 0) return 1;
    if (c < 4)  return 2 ** int'(c);
    if (c < 10) return (c[0] == 1'b0) ? 6 : 8;
    t = (c < 13) ? int'(c) - 10 : int'(c) - 13;
    return (t == 0) ? 5 : (t == 1) ? 6 : 8;
  endfunction

  // scoreboard driver side: predicts the level after each edge
  bit         exp_q[$];
  bit         m_s1, m_s2, m_filt;
  int         m_run, m_div;
  logic [3:0] m_code;

  always @(posedge clk) begin
    bit tk;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_filt = 0; m_run = 0; m_div = 0; m_code = 0;
    end else begin
      if (code != m_code) begin
        m_code = code; m_div = 0; m_run = 0; tk = 0;
      end else begin
        if (code < 4) tk = 1;
        else if (dt_en) begin
          m_div++;
          tk = (m_div == ratio_of(code));
          if (tk) m_div = 0;
        end else tk = 0;
        if (tk) begin
          if (m_s2 == m_filt) m_run = 0;
          else if (m_run + 1 == runlen_of(code)) begin m_filt = m_s2; m_run = 0; end
          else m_run++;
        end
      end
      m_s2 = m_s1; m_s1 = raw;
    end
    exp_q.push_back(m_filt);
  end

  // scoreboard monitor side
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      n_checks++;
      if (filt !== e) begin
        n_fail++;
        $display("FAIL %s code=%0d: filt=%0b expected %0b at %0t", cur_req, code, filt, e, $time);
      end
    end
  end

  task automatic chk(input string req, input bit exp_v);
    n_checks++;
    if (filt !== exp_v) begin
      n_fail++;
      $display("FAIL %s directed: filt=%0b expected %0b", req, filt, exp_v);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_kernel(input logic [3:0] c);
    int n;
    n = runlen_of(c);
    code = c; wait_neg(4);
    raw = ~filt;                 // glitch one sample short of N
    wait_neg(n - 1); raw = filt; wait_neg(n + 4);
    chk("R7", raw);
    raw = ~filt; wait_neg(n + 4); // full-length pulse
    chk("R4", raw);
  endtask

  initial begin
    wait_neg(3);
    chk("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk); chk("R1", 1'b0);

    // R2 / R3: code 0 latency and pass-through
    cur_req = "R2"; raw = 1'b1;
    wait_neg(2); chk("R2", 1'b0);
    wait_neg(1); chk("R2", 1'b1);
    cur_req = "R3"; raw = 1'b0; wait_neg(1); raw = 1'b1; wait_neg(1); raw = 1'b0;
    wait_neg(5); chk("R3", 1'b0);

    cur_req = "R4";
    for (int c = 1; c < 4; c++) run_kernel(4'(c));

    // R5 / R6: dead-time codes
    cur_req = "R5/R6"; dt_run = 1'b1;
    for (int c = 4; c < 16; c++) begin
      int span;
      span = 3 * ratio_of(4'(c)) * (runlen_of(4'(c)) + 2) + 6;
      code = 4'(c); wait_neg(3);
      raw = ~raw; wait_neg(span); chk("R6", raw);
      raw = ~raw; wait_neg(3 * ratio_of(4'(c)) * 2);       // short glitch
      raw = ~raw; wait_neg(span); chk("R5", raw);
    end

    // R9: no enable, no change
    cur_req = "R9"; code = 4'd4; dt_run = 1'b0; wait_neg(3);
    raw = ~filt; wait_neg(60); chk("R9", ~raw);
    raw = filt;  wait_neg(4);

    // R8: code change in the middle of a run
    cur_req = "R8"; code = 4'd3; wait_neg(4);
    raw = ~filt; wait_neg(7);
    code = 4'd2; @(negedge clk); chk("R8", ~raw);
    wait_neg(2); chk("R8", ~raw);
    wait_neg(6); chk("R8", raw);

    wait_neg(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: expired, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule